// File: doc/BRIEF.md
# Supply Loss Backup Controller

This block watches two digital status lines coming from analog supply monitors: one reports that the supply voltage has sagged, the other that the supply has gone away entirely. A small control register tells it which reactions are allowed. A sagging supply can stop the CPU and switch the PLL to its off mode. A lost supply puts the whole chip into a backup state. In that state the CPU and PLL stop, push-pull and display outputs are driven low, and open-drain outputs are released.

When the supply comes back, the CPU stays held for a 100 ms standby interval before it may run again. A sticky flag records that the supply was lost, so firmware can find out after restart what happened. Firmware reads and writes the control register and the flag over a plain single-cycle register port. Reads are combinational on the address and writes take effect at the clock edge. There is no stream data path, so no valid/ready handshake is involved.

Top module: `supply_backup_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0, the loss flag (address 1, bit 0) reads 0, `cpu_hold_o`, `cpu_stop_o` and `pll_off_o` are low, and the pin inputs pass unchanged to the pin outputs.
- R2: While control bit 0 (sag-detect enable) is 0, the sag input has no effect on `cpu_stop_o` or `pll_off_o`, even with control bits 1 and 2 set.
- R3: With control bits 0 and 1 set (sag-detect enable, PLL-stop enable), a high sag input drives `pll_off_o` high. It leaves `cpu_stop_o` low when control bit 2 is 0.
- R4: With control bits 0 and 2 set (sag-detect enable, CPU-stop enable), a high sag input drives `cpu_stop_o` high. It leaves `pll_off_o` low when control bit 1 is 0.
- R5: While control bit 3 (supply-off enable) is 0, the supply-off input causes no hold and does not set the loss flag.
- R6: During a supply-off event, and until the CPU is released, `cpu_hold_o`, `cpu_stop_o` and `pll_off_o` are high. `cmos_out_o` and `lcd_out_o` are all zero and `od_oe_o` is all zero (high impedance). Otherwise every pin output equals its input.
- R7: Once the synchronized supply-off input falls, the CPU stays held for exactly CLK_HZ/10 further cycles before `cpu_hold_o` drops.
- R8: If the supply-off input reasserts during the standby interval, the interval restarts from zero after the next release.
- R9: A supply-off event sets the loss flag (address 1, bit 0). The flag stays set after the CPU is released.
- R10: Writing 1 to address 1 bit 0 clears the loss flag. Writing 0 there leaves it unchanged.
- R11: A set condition in the same cycle as a clear write wins, so the flag cannot be cleared while the supply-off condition persists.
- R12: Both status inputs pass through a two-flop synchronizer. A change on the sag input first affects `pll_off_o`/`cpu_stop_o` after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sag_i | input | 1 | Supply-sag indication (asynchronous) |
| supply_off_i | input | 1 | Supply-lost indication (asynchronous) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address (0 control, 1 flag) |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational on address |
| cmos_in_i | input | N_CMOS | Functional values for push-pull outputs |
| lcd_in_i | input | N_LCD | Functional values for display outputs |
| od_pull_i | input | N_OD | Functional pull-low enables for open-drain outputs |
| cmos_out_o | output | N_CMOS | Push-pull outputs after safe-state gating |
| lcd_out_o | output | N_LCD | Display outputs after safe-state gating |
| od_oe_o | output | N_OD | Open-drain drive enables (0 = high impedance) |
| cpu_stop_o | output | 1 | CPU stop request |
| pll_off_o | output | 1 | PLL off-mode and stop request |
| cpu_hold_o | output | 1 | CPU held in backup/standby |

## Verification
The assertions assume the two status inputs are level signals that hold each value for several clocks, and that firmware does not rewrite the control register in the middle of a backup sequence. The stimulus changes the status lines only on falling clock edges and keeps each level for at least four cycles. It rewrites the control register only while no hold is active, apart from the deliberate flag-clear attempt made during a supply-off event.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_OFF     = 2'd1,
    ST_STANDBY = 2'd2
  } sbc_state_e;

  // control register layout; the bench relies on these positions
  typedef struct packed {
    logic off_en;    // bit 3
    logic cpu_en;    // bit 2
    logic pll_en;    // bit 1
    logic sag_en;    // bit 0
  } sbc_ctrl_t;

  localparam int CTRL_W   = 4;
  localparam int ADR_CTRL = 0;
  localparam int ADR_FLAG = 1;
endpackage

// File: rtl/sbc_sync.sv
module sbc_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/sbc_regs.sv
module sbc_regs
  import sbc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              flag_set_i,
  output sbc_ctrl_t         ctrl_o,
  output logic              flag_o
);
  logic wr_ctrl, wr_flag;
  assign wr_ctrl = we_i && (addr_i == ADDR_W'(ADR_CTRL));
  assign wr_flag = we_i && (addr_i == ADDR_W'(ADR_FLAG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '0;
    end else if (wr_ctrl) begin
      ctrl_o <= sbc_ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  // set has priority over the write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else if (flag_set_i) begin
      flag_o <= 1'b1;
    end else if (wr_flag && wdata_i[0]) begin
      flag_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADR_CTRL)) begin
      rdata_o[CTRL_W-1:0] = ctrl_o;
    end else if (addr_i == ADDR_W'(ADR_FLAG)) begin
      rdata_o[0] = flag_o;
    end
  end
endmodule

// File: rtl/sbc_standby.sv
module sbc_standby
  import sbc_pkg::*;
#(
  parameter int WAIT_CYC = 3276
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       off_evt_i,
  output sbc_state_e state_o
);
  localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= ST_RUN;
      cnt     <= '0;
    end else begin
      unique case (state_o)
        ST_RUN: begin
          if (off_evt_i) state_o <= ST_OFF;
        end
        ST_OFF: begin
          if (!off_evt_i) begin
            state_o <= ST_STANDBY;
            cnt     <= '0;
          end
        end
        ST_STANDBY: begin
          if (off_evt_i) begin
            state_o <= ST_OFF;
          end else if (cnt == CNT_W'(WAIT_CYC - 1)) begin
            state_o <= ST_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state_o <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/supply_backup_ctrl.sv
module supply_backup_ctrl
  import sbc_pkg::*;
#(
  parameter int CLK_HZ = 32768,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int N_CMOS = 8,
  parameter int N_LCD  = 16,
  parameter int N_OD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sag_i,
  input  logic              supply_off_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [N_CMOS-1:0] cmos_in_i,
  input  logic [N_LCD-1:0]  lcd_in_i,
  input  logic [N_OD-1:0]   od_pull_i,
  output logic [N_CMOS-1:0] cmos_out_o,
  output logic [N_LCD-1:0]  lcd_out_o,
  output logic [N_OD-1:0]   od_oe_o,
  output logic              cpu_stop_o,
  output logic              pll_off_o,
  output logic              cpu_hold_o
);
  localparam int WAIT_CYC = CLK_HZ / 10;

  logic [1:0] sync_q;
  logic       sag_s, off_s, off_evt, sag_hit, loss_flag;
  sbc_ctrl_t  ctrl;
  sbc_state_e state;

  sbc_sync #(.W(2)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({supply_off_i, sag_i}),
    .q_o   (sync_q)
  );
  assign sag_s = sync_q[0];
  assign off_s = sync_q[1];

  assign off_evt = off_s && ctrl.off_en;
  assign sag_hit = sag_s && ctrl.sag_en;

  sbc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .flag_set_i (off_evt),
    .ctrl_o     (ctrl),
    .flag_o     (loss_flag)
  );

  sbc_standby #(.WAIT_CYC(WAIT_CYC)) stby_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .off_evt_i (off_evt),
    .state_o   (state)
  );

  assign cpu_hold_o = (state != ST_RUN);
  assign cpu_stop_o = cpu_hold_o || (sag_hit && ctrl.cpu_en);
  assign pll_off_o  = cpu_hold_o || (sag_hit && ctrl.pll_en);
  assign cmos_out_o = cpu_hold_o ? '0 : cmos_in_i;
  assign lcd_out_o  = cpu_hold_o ? '0 : lcd_in_i;
  assign od_oe_o    = cpu_hold_o ? '0 : od_pull_i;
endmodule

// File: rtl/sbc_chk.sv
module sbc_chk #(
  parameter int N_CMOS = 8,
  parameter int N_LCD  = 16,
  parameter int N_OD   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_hold,
  input logic              cpu_stop,
  input logic              pll_off,
  input logic [N_CMOS-1:0] cmos_in,
  input logic [N_CMOS-1:0] cmos_out,
  input logic [N_LCD-1:0]  lcd_out,
  input logic [N_OD-1:0]   od_oe,
  input logic              sag_en,
  input logic              off_evt,
  input logic              flag
);
  // R2
  sag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sag_en && !cpu_hold) |-> (!cpu_stop && !pll_off));

  // R6
  safe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hold |-> (cmos_out == '0 && lcd_out == '0 && od_oe == '0 && pll_off && cpu_stop));

  // R6
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_hold |-> (cmos_out == cmos_in));

  // R9
  flag_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_hold) |-> flag);

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_evt |=> flag);

  // R8
  hold_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_evt && cpu_hold) |=> cpu_hold);

  // R7
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> $past(!off_evt));
endmodule

bind supply_backup_ctrl sbc_chk #(
  .N_CMOS (N_CMOS),
  .N_LCD  (N_LCD),
  .N_OD   (N_OD)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_hold (cpu_hold_o),
  .cpu_stop (cpu_stop_o),
  .pll_off  (pll_off_o),
  .cmos_in  (cmos_in_i),
  .cmos_out (cmos_out_o),
  .lcd_out  (lcd_out_o),
  .od_oe    (od_oe_o),
  .sag_en   (ctrl.sag_en),
  .off_evt  (off_evt),
  .flag     (loss_flag)
);

// File: tb/supply_backup_ctrl_tb_top.sv
`timescale 1ns/1ps
module supply_backup_ctrl_tb_top;
  localparam int CLK_HZ = 10000;
  localparam int WAIT   = CLK_HZ / 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int N_CMOS = 8;
  localparam int N_LCD  = 16;
  localparam int N_OD   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sag = 1'b0, soff = 1'b0;
  logic we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic [N_CMOS-1:0] cmos_in = 8'hA5, cmos_out;
  logic [N_LCD-1:0]  lcd_in = 16'h3C5A, lcd_out;
  logic [N_OD-1:0]   od_in = 4'b1011, od_oe;
  logic cpu_stop, pll_off, cpu_hold;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  supply_backup_ctrl #(
    .CLK_HZ(CLK_HZ), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .N_CMOS(N_CMOS), .N_LCD(N_LCD), .N_OD(N_OD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sag_i(sag), .supply_off_i(soff),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cmos_in_i(cmos_in), .lcd_in_i(lcd_in), .od_pull_i(od_in),
    .cmos_out_o(cmos_out), .lcd_out_o(lcd_out), .od_oe_o(od_oe),
    .cpu_stop_o(cpu_stop), .pll_off_o(pll_off), .cpu_hold_o(cpu_hold)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    addr = ADDR_W'(a);
    wdata = DATA_W'(d);
    we = 1'b1;
    tick(1);
    we = 1'b0;
  endtask

  function automatic logic [31:0] rd(input int a);
    return 32'(rdata);
  endfunction

  task automatic read_chk(input string req, input int a, input int exp);
    addr = ADDR_W'(a);
    #1;
    check(req, 32'(rdata), 32'(exp));
  endtask

  task automatic t_reset;
    read_chk("R1 ctrl", 0, 0);
    read_chk("R1 flag", 1, 0);
    check("R1 hold", 32'(cpu_hold), 0);
    check("R1 stop", 32'({cpu_stop, pll_off}), 0);
    check("R1 cmos", 32'(cmos_out), 32'(cmos_in));
    check("R1 od", 32'(od_oe), 32'(od_in));
  endtask

  task automatic t_sag_disabled;
    wr(0, 4'b0110);
    sag = 1'b1;
    tick(4);
    check("R2 cpu_stop", 32'(cpu_stop), 0);
    check("R2 pll_off", 32'(pll_off), 0);
    sag = 1'b0;
    tick(4);
  endtask

  task automatic t_pll_stop;
    wr(0, 4'b0011);
    sag = 1'b1;
    tick(1);
    check("R12 one edge", 32'(pll_off), 0);
    tick(1);
    check("R12 two edges", 32'(pll_off), 1);
    check("R3 pll_off", 32'(pll_off), 1);
    check("R3 cpu_stop", 32'(cpu_stop), 0);
    sag = 1'b0;
    tick(3);
    check("R3 released", 32'(pll_off), 0);
  endtask

  task automatic t_cpu_stop;
    wr(0, 4'b0101);
    sag = 1'b1;
    tick(3);
    check("R4 cpu_stop", 32'(cpu_stop), 1);
    check("R4 pll_off", 32'(pll_off), 0);
    sag = 1'b0;
    tick(3);
    check("R4 released", 32'(cpu_stop), 0);
  endtask

  task automatic t_off_disabled;
    wr(0, 4'b0111);
    soff = 1'b1;
    tick(5);
    check("R5 hold", 32'(cpu_hold), 0);
    read_chk("R5 flag", 1, 0);
    soff = 1'b0;
    tick(4);
  endtask

  task automatic t_off_event;
    wr(0, 4'b1000);
    soff = 1'b1;
    tick(4);
    check("R6 hold", 32'(cpu_hold), 1);
    check("R6 cmos", 32'(cmos_out), 0);
    check("R6 lcd", 32'(lcd_out), 0);
    check("R6 od", 32'(od_oe), 0);
    check("R6 stops", 32'({cpu_stop, pll_off}), 32'h3);
    read_chk("R9 flag set", 1, 1);
    wr(1, 1);
    read_chk("R11 clear loses", 1, 1);
    soff = 1'b0;
    tick(WAIT + 1);
    check("R7 still held", 32'(cpu_hold), 1);
    tick(3);
    check("R7 released", 32'(cpu_hold), 0);
    check("R7 cmos back", 32'(cmos_out), 32'(cmos_in));
    check("R7 lcd back", 32'(lcd_out), 32'(lcd_in));
    read_chk("R9 sticky", 1, 1);
    wr(1, 0);
    read_chk("R10 write 0", 1, 1);
    wr(1, 1);
    read_chk("R10 write 1", 1, 0);
  endtask

  task automatic t_restart;
    soff = 1'b1;
    tick(4);
    soff = 1'b0;
    tick(WAIT / 2);
    check("R8 mid standby", 32'(cpu_hold), 1);
    soff = 1'b1;
    tick(4);
    soff = 1'b0;
    tick(WAIT + 1);
    check("R8 restarted", 32'(cpu_hold), 1);
    tick(3);
    check("R8 released", 32'(cpu_hold), 0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_sag_disabled();
    t_pll_stop();
    t_cpu_stop();
    t_off_disabled();
    t_off_event();
    t_restart();
    tick(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule